// File: doc/BRIEF.md
# Tag-Only Wakeup Scheduler Window

This block holds dispatched instructions until their sources are available and then sends them to execution. It keeps no operand values. Each window entry stores three register specifiers: two sources and one destination. When an execution unit finishes, it presents its destination specifier together with the result. The specifier wakes every entry that waits on it. The result goes only into the physical register file, which this block owns.

Each cycle, up to two ready entries are chosen, oldest first. In the same cycle their sources are read from the register file through write-through bypass. The chosen instructions leave on registered issue slots one cycle later, with their operand values attached. A per-register ready scoreboard decides at dispatch whether a source is already available.

Top module: `tagwake_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both issue slots are invalid and `disp_full` is low. Every physical register reads as zero and is marked available.
- R2: A dispatch stores only the three specifiers. A source counts as ready at dispatch if its register is marked available in the scoreboard, or if it matches a broadcast in that same cycle.
- R3: A broadcast tag sets the ready flag of every waiting source whose specifier matches. An entry whose last source is woken by a broadcast may be selected in that same cycle.
- R4: In each cycle, the number of issued instructions is the smaller of 2 and the number of ready entries. The entries chosen are the oldest ready ones, where age is the order of dispatch.
- R5: An instruction selected in cycle c appears on an issue slot in cycle c+1 with its destination specifier and both operand values. The operands are read in cycle c, and a register written in cycle c supplies the new value (bypass). If both write ports target the same register, port 1 wins.
- R6: `disp_full` is high exactly when every entry is occupied. A dispatch presented while it is high is ignored and never issues. An entry becomes free in the cycle after it is selected.
- R7: A dispatch marks its destination register unavailable, and a broadcast marks its tag available. If both touch the same register in the same cycle, the dispatch wins.
- R8: When both slots are valid, slot 1 carries the younger instruction. Slot 1 is never valid while slot 0 is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src_a | input | TW | First source specifier |
| disp_src_b | input | TW | Second source specifier |
| disp_dst | input | TW | Destination specifier |
| disp_full | output | 1 | All window entries occupied |
| wb_valid | input | NWB | Per-port completion strobe |
| wb_tag | input | NWB*TW | Completion destination specifiers, port w at bits [w*TW +: TW] |
| wb_data | input | NWB*DW | Completion results, written to the register file only |
| iss_vld | output | 2 | Issue slot valid, bit 0 is slot 0 |
| iss_dst | output | 2*TW | Destination specifier per slot |
| iss_opa | output | 2*DW | First operand value per slot |
| iss_opb | output | 2*DW | Second operand value per slot |

## Verification
Some properties are checked on every cycle:
- slot ordering;
- the occupancy balance between dispatches and issues;
- the rule that issue width equals the smaller of 2 and the number of ready entries;
- the rule that a dispatched destination is pending in the next cycle.

Other behaviour can only be shown by scenarios, because it depends on comparing data values: which entries are oldest, the operand values seen through bypass, the dispatch that is dropped when the window is full, and the case where a dispatch and a broadcast hit the same register in one cycle. The bench covers these with a cycle model, using directed sequences and seeded random traffic.

// File: rtl/tagwake_sched.sv
module tagwake_sched #(
  parameter int ENTRIES = 8,
  parameter int TAGS    = 16,
  parameter int DW      = 32,
  parameter int NWB     = 2,
  localparam int TW     = $clog2(TAGS),
  localparam int EW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [TW-1:0]     disp_src_a,
  input  logic [TW-1:0]     disp_src_b,
  input  logic [TW-1:0]     disp_dst,
  output logic              disp_full,
  input  logic [NWB-1:0]    wb_valid,
  input  logic [NWB*TW-1:0] wb_tag,
  input  logic [NWB*DW-1:0] wb_data,
  output logic [1:0]        iss_vld,
  output logic [2*TW-1:0]   iss_dst,
  output logic [2*DW-1:0]   iss_opa,
  output logic [2*DW-1:0]   iss_opb
);

  logic [ENTRIES-1:0] ent_v, rdy_a, rdy_b, hit_a, hit_b, cand, cand1, pick0, pick1;
  logic [TW-1:0]      tag_a [ENTRIES];
  logic [TW-1:0]      tag_b [ENTRIES];
  logic [TW-1:0]      tag_d [ENTRIES];
  logic [ENTRIES-1:0] older [ENTRIES];
  logic [TAGS-1:0]    sb;
  logic [DW-1:0]      rf [TAGS];
  logic [EW-1:0]      free_i, sel_i [2];
  logic               do_disp, d_ra, d_rb;
  logic [DW-1:0]      rd_a [2];
  logic [DW-1:0]      rd_b [2];

  assign disp_full = &ent_v;
  assign do_disp   = disp_valid & ~disp_full;

  always_comb begin
    hit_a = '0;
    hit_b = '0;
    d_ra  = sb[disp_src_a];
    d_rb  = sb[disp_src_b];
    for (int w = 0; w < NWB; w++) begin
      if (wb_valid[w]) begin
        if (wb_tag[w*TW +: TW] == disp_src_a) d_ra = 1'b1;
        if (wb_tag[w*TW +: TW] == disp_src_b) d_rb = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (wb_tag[w*TW +: TW] == tag_a[i]) hit_a[i] = 1'b1;
          if (wb_tag[w*TW +: TW] == tag_b[i]) hit_b[i] = 1'b1;
        end
      end
    end
  end

  assign cand  = ent_v & (rdy_a | hit_a) & (rdy_b | hit_b);
  assign cand1 = cand & ~pick0;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pick0[i] = cand[i]  & ~|(older[i] & cand);
      pick1[i] = cand1[i] & ~|(older[i] & cand1);
    end
  end

  always_comb begin
    free_i   = '0;
    sel_i[0] = '0;
    sel_i[1] = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_v[i]) free_i = EW'(i);
    for (int i = 0; i < ENTRIES; i++) begin
      if (pick0[i]) sel_i[0] = EW'(i);
      if (pick1[i]) sel_i[1] = EW'(i);
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rd_a[s] = rf[tag_a[sel_i[s]]];
      rd_b[s] = rf[tag_b[sel_i[s]]];
      for (int w = 0; w < NWB; w++) begin
        if (wb_valid[w] && wb_tag[w*TW +: TW] == tag_a[sel_i[s]]) rd_a[s] = wb_data[w*DW +: DW];
        if (wb_valid[w] && wb_tag[w*TW +: TW] == tag_b[sel_i[s]]) rd_b[s] = wb_data[w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v   <= '0;
      rdy_a   <= '0;
      rdy_b   <= '0;
      sb      <= '1;
      iss_vld <= '0;
      iss_dst <= '0;
      iss_opa <= '0;
      iss_opb <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        older[i] <= '0;
        tag_a[i] <= '0;
        tag_b[i] <= '0;
        tag_d[i] <= '0;
      end
      for (int t = 0; t < TAGS; t++) rf[t] <= '0;
    end else begin
      rdy_a <= rdy_a | hit_a;
      rdy_b <= rdy_b | hit_b;
      ent_v <= ent_v & ~pick0 & ~pick1;
      for (int w = 0; w < NWB; w++) begin
        if (wb_valid[w]) begin
          rf[wb_tag[w*TW +: TW]] <= wb_data[w*DW +: DW];
          sb[wb_tag[w*TW +: TW]] <= 1'b1;
        end
      end
      if (do_disp) begin
        for (int i = 0; i < ENTRIES; i++) older[i][free_i] <= 1'b0;
        older[free_i] <= ent_v & ~pick0 & ~pick1;
        ent_v[free_i] <= 1'b1;
        tag_a[free_i] <= disp_src_a;
        tag_b[free_i] <= disp_src_b;
        tag_d[free_i] <= disp_dst;
        rdy_a[free_i] <= d_ra;
        rdy_b[free_i] <= d_rb;
        sb[disp_dst]  <= 1'b0;
      end
      iss_vld <= {|pick1, |pick0};
      for (int s = 0; s < 2; s++) begin
        iss_dst[s*TW +: TW] <= tag_d[sel_i[s]];
        iss_opa[s*DW +: DW] <= rd_a[s];
        iss_opb[s*DW +: DW] <= rd_b[s];
      end
    end
  end

endmodule

// File: rtl/tagwake_sched_chk.sv
module tagwake_sched_chk #(
  parameter int ENTRIES = 8,
  parameter int TAGS    = 16,
  parameter int TW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               disp_full,
  input logic [TW-1:0]      disp_dst,
  input logic [1:0]         iss_vld,
  input logic [ENTRIES-1:0] ent_v,
  input logic [ENTRIES-1:0] cand,
  input logic [TAGS-1:0]    sb
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> iss_vld == 2'b00);

  // R8
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> iss_vld[0]);

  // R4
  issue_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (int'($countones(iss_vld)) ==
               (($past(int'($countones(cand))) > 2) ? 2 : $past(int'($countones(cand))))));

  // R6
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (int'($countones(ent_v)) ==
               $past(int'($countones(ent_v))) + int'($past(disp_valid && !disp_full))
               - int'($countones(iss_vld))));

  // R7
  dst_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_full) |=> !sb[$past(disp_dst)]);

endmodule

bind tagwake_sched tagwake_sched_chk #(.ENTRIES(ENTRIES), .TAGS(TAGS), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_full(disp_full),
  .disp_dst(disp_dst), .iss_vld(iss_vld), .ent_v(ent_v), .cand(cand), .sb(sb)
);

// File: tb/tagwake_sched_tb_top.sv
module tagwake_sched_tb_top;
  localparam int E = 8, T = 16, D = 32, W = 2, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [TW-1:0] disp_src_a = '0, disp_src_b = '0, disp_dst = '0;
  logic disp_full;
  logic [W-1:0] wb_valid = '0;
  logic [W*TW-1:0] wb_tag = '0;
  logic [W*D-1:0] wb_data = '0;
  logic [1:0] iss_vld;
  logic [2*TW-1:0] iss_dst;
  logic [2*D-1:0] iss_opa, iss_opb;

  always #2 clk = ~clk;

  tagwake_sched #(.ENTRIES(E), .TAGS(T), .DW(D), .NWB(W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit mv[E], mra[E], mrb[E];
  int mseq[E];
  logic [TW-1:0] msa[E], msb[E], msd[E];
  bit sbm[T];
  logic [D-1:0] rfm[T];
  int seqc = 0;
  bit ev[2];
  logic [TW-1:0] ed[2];
  logic [D-1:0] ea[2], eb[2];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hit(input logic [TW-1:0] t, input bit [1:0] wv, input logic [TW-1:0] t0, t1);
    return (wv[0] && t0 == t) || (wv[1] && t1 == t);
  endfunction

  function automatic logic [D-1:0] rdv(input logic [TW-1:0] t, input bit [1:0] wv,
                                       input logic [TW-1:0] t0, t1, input logic [D-1:0] d0, d1);
    if (wv[1] && t1 == t) return d1;
    if (wv[0] && t0 == t) return d0;
    return rfm[t];
  endfunction

  task automatic step(input string ctx, input bit dv, input logic [TW-1:0] s1, s2, dd,
                      input bit [1:0] wv, input logic [TW-1:0] t0, t1, input logic [D-1:0] d0, d1);
    bit full;
    bit cand[E];
    int p[2];
    int fi;
    full = 1'b1;
    for (int i = 0; i < E; i++) if (!mv[i]) full = 1'b0;
    chk(disp_full == full, {ctx, " R6 full flag"}, disp_full, full);
    disp_valid = dv; disp_src_a = s1; disp_src_b = s2; disp_dst = dd;
    wb_valid = wv; wb_tag = {t1, t0}; wb_data = {d1, d0};
    for (int i = 0; i < E; i++)
      cand[i] = mv[i] && (mra[i] || hit(msa[i], wv, t0, t1)) && (mrb[i] || hit(msb[i], wv, t0, t1));
    p[0] = -1; p[1] = -1;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < E; i++)
        if (cand[i] && i != p[0] && (p[s] < 0 || mseq[i] < mseq[p[s]])) p[s] = i;
    for (int s = 0; s < 2; s++) begin
      ev[s] = p[s] >= 0;
      if (ev[s]) begin
        ed[s] = msd[p[s]];
        ea[s] = rdv(msa[p[s]], wv, t0, t1, d0, d1);
        eb[s] = rdv(msb[p[s]], wv, t0, t1, d0, d1);
      end
    end
    fi = -1;
    for (int i = E - 1; i >= 0; i--) if (!mv[i]) fi = i;
    for (int i = 0; i < E; i++) begin
      mra[i] = mra[i] | hit(msa[i], wv, t0, t1);
      mrb[i] = mrb[i] | hit(msb[i], wv, t0, t1);
    end
    for (int s = 0; s < 2; s++) if (p[s] >= 0) mv[p[s]] = 1'b0;
    if (dv && !full) begin
      mv[fi] = 1'b1; msa[fi] = s1; msb[fi] = s2; msd[fi] = dd; mseq[fi] = seqc++;
      mra[fi] = sbm[s1] || hit(s1, wv, t0, t1);
      mrb[fi] = sbm[s2] || hit(s2, wv, t0, t1);
    end
    if (wv[0]) begin rfm[t0] = d0; sbm[t0] = 1'b1; end
    if (wv[1]) begin rfm[t1] = d1; sbm[t1] = 1'b1; end
    if (dv && !full) sbm[dd] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk(iss_vld[s] == ev[s], {ctx, " R4 slot valid"}, iss_vld[s], ev[s]);
      if (ev[s] && iss_vld[s]) begin
        chk(iss_dst[s*TW +: TW] == ed[s], {ctx, " R4 R8 slot dst"}, iss_dst[s*TW +: TW], ed[s]);
        chk(iss_opa[s*D +: D] == ea[s], {ctx, " R5 operand a"}, iss_opa[s*D +: D], ea[s]);
        chk(iss_opb[s*D +: D] == eb[s], {ctx, " R5 operand b"}, iss_opb[s*D +: D], eb[s]);
      end
    end
  endtask

  task automatic idle(input string ctx, input int n);
    for (int k = 0; k < n; k++) step(ctx, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < T; t++) begin sbm[t] = 1'b1; rfm[t] = '0; end
    for (int i = 0; i < E; i++) begin mv[i] = 0; mra[i] = 0; mrb[i] = 0; mseq[i] = 0; end
    repeat (3) @(negedge clk);
    chk(iss_vld == 2'b00, "R1 issue idle in reset", iss_vld, 0);
    chk(disp_full == 1'b0, "R1 window empty in reset", disp_full, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_vld == 2'b00, "R1 issue idle after reset", iss_vld, 0);
    // R2: ready sources at reset read zero
    step("R2", 1, 4'd1, 4'd2, 4'd3, 2'b00, 0, 0, 0, 0);
    // R7: consumer of pending dst 3 waits
    step("R7", 1, 4'd3, 4'd1, 4'd4, 2'b00, 0, 0, 0, 0);
    idle("R7", 2);
    // R3: broadcast wakes and bypass supplies value the same cycle
    step("R3", 0, 0, 0, 0, 2'b01, 4'd3, 0, 32'hABCD_0001, 0);
    step("R3", 0, 0, 0, 0, 2'b01, 4'd4, 0, 32'h4444_0004, 0);
    // R7: dispatch and broadcast on same register, dispatch wins
    step("R7", 1, 4'd1, 4'd1, 4'd5, 2'b01, 4'd5, 0, 32'h5555, 0);
    step("R7", 1, 4'd5, 4'd0, 4'd6, 2'b00, 0, 0, 0, 0);
    idle("R7", 2);
    step("R5", 0, 0, 0, 0, 2'b11, 4'd5, 4'd5, 32'h1111, 32'h2222);
    idle("R5", 1);
    // R6: fill the window, extra dispatch dropped, drain oldest first
    step("R6", 1, 4'd0, 4'd0, 4'd9, 2'b00, 0, 0, 0, 0);
    for (int k = 0; k < E; k++) step("R6", 1, 4'd9, 4'(k), 4'(10 + (k % 6)), 2'b00, 0, 0, 0, 0);
    step("R6", 1, 4'd0, 4'd0, 4'd2, 2'b00, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 2'b01, 4'd9, 0, 32'h9999_0009, 0);
    idle("R8", 6);
    for (int c = 0; c < 3000; c++) begin
      bit [1:0] wv;
      logic [TW-1:0] t0, t1;
      wv = {($urandom % 10) < 3, ($urandom % 10) < 4};
      t0 = 4'($urandom % T);
      t1 = 4'($urandom % T);
      if (wv == 2'b11 && t0 == t1) wv[1] = 1'b0;
      step("RND", ($urandom % 10) < 6, 4'($urandom % T), 4'($urandom % T), 4'($urandom % T),
           wv, t0, t1, $urandom, $urandom);
    end
    for (int t = 0; t < T; t += 2) step("RND", 0, 0, 0, 0, 2'b11, 4'(t), 4'(t + 1), $urandom, $urandom);
    idle("R6", 4);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule